// File: doc/BRIEF.md
# DRAM Refresh Controller with Self-Refresh

This block keeps an asynchronous DRAM alive. A programmable interval timer raises refresh requests. Each request is served as one CAS-before-RAS (CBR) cycle once the memory sequencer acknowledges that no access is in progress. Every completed CBR cycle advances a refresh event counter. When the counter reaches a programmed limit it sets an overflow flag, which can raise an interrupt. Software can therefore run a burst of refreshes at a short interval after leaving self-refresh, and go back to the slow low-power interval when the interrupt arrives.

The block also enters and leaves DRAM self-refresh on request, in any power mode. It decides whether the RAS and CAS pins keep being driven while the rest of the bus floats, which happens during a bus release or in standby. Configuration arrives over a plain register write port. The port has no back-pressure: a write is taken in every cycle in which `wr_en` is high. Power mode, bus release, the request/acknowledge pair and the pins are all plain level signals.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: With refresh enabled (control bit 0) and `pwr_mode` normal (00), sleep (01) or manual reset (11), the timer counts from 0 up to the interval register (address 0) and then wraps. CBR cycles therefore start every interval+1 clocks when `ref_ack` stays high.
- R2: A CBR cycle drives CAS low one clock before RAS. CAS stays low for L+1 clocks and RAS stays low for L+1 clocks, where L is the RAS length field (control bits 7:5, reset value 3). CAS returns high one clock before RAS.
- R3: Each completed CBR cycle increments the refresh count. A completion that finds the count equal to the limit register (address 1) sets the overflow flag and wraps the count to 0, so with limit N the flag sets on the (N+1)th refresh.
- R4: `irq` is high exactly when the overflow flag is set and the interrupt enable (control bit 2) is 1. Writing a control word with bit 4 set clears the flag. A flag that sets in the same cycle as a clear stays set.
- R5: Any write to address 2 clears the refresh count to zero, which restarts the count towards overflow.
- R6: In standby (`pwr_mode` 10) the timer is held and no CBR cycle starts. Refreshing resumes when the block leaves standby.
- R7: A CBR cycle or a self-refresh entry starts only in a cycle where `ref_ack` is high. While it waits, `ref_req` stays high. At most one request is pending, so timer expiries that arrive while one is pending are dropped.
- R8: Setting the self-refresh bit (control bit 1) performs a CBR entry (CAS low, RAS low one clock later) and then holds both pins low in every power mode, standby included. Clearing the bit raises RAS first and CAS one clock later.
- R9: After a self-refresh exit or a CBR cycle, both pins stay high for P clocks, where P is the precharge field (control bits 10:8), before the block returns to idle. A pending refresh then starts one clock later.
- R10: When `bus_released` is high or the block is in standby, `ras_oe` and `cas_oe` are low unless the keep-driving bit (control bit 3) is 1. In every other case both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 interval, 1 limit, 2 count clear, 3 control |
| wr_data | input | 16 | Register write data |
| pwr_mode | input | 2 | 00 normal, 01 sleep, 10 standby, 11 manual reset |
| bus_released | input | 1 | Bus currently granted to another master |
| ref_ack | input | 1 | Memory sequencer idle, so a refresh may start |
| ref_req | output | 1 | Refresh or self-refresh wanted or in progress |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| ras_oe | output | 1 | Output enable for the row strobe |
| cas_oe | output | 1 | Output enable for the column strobe |
| irq | output | 1 | Refresh count overflow interrupt |

## Verification
The assertions check the following on every cycle:
- RAS never falls unless CAS is already low from the previous clock.
- No strobe activity begins without `ref_ack`, and no CBR cycle begins in standby.
- `ref_req` covers every clock in which CAS is low.
- The interrupt never appears while it is disabled.
- The pins are driven or floated according to the bus-release, standby and keep-driving rules.
- A self-refresh exit follows a cleared request.

Only the bench scenarios can show the rest:
- the exact refresh period;
- the strobe widths for each RAS length;
- the clock on which the overflow interrupt rises for a given limit, and the restart after a count clear;
- that expiries are dropped while a request waits;
- the precharge gap between a self-refresh exit and the next CBR cycle.

// File: rtl/drc_pkg.sv
package drc_pkg;
  localparam int LEN_W = 3;

  localparam logic [1:0] ADDR_INTERVAL = 2'd0;
  localparam logic [1:0] ADDR_LIMIT    = 2'd1;
  localparam logic [1:0] ADDR_CLEAR    = 2'd2;
  localparam logic [1:0] ADDR_CTRL     = 2'd3;

  localparam int CB_REF_EN  = 0;
  localparam int CB_SR_EN   = 1;
  localparam int CB_IRQ_EN  = 2;
  localparam int CB_KEEP    = 3;
  localparam int CB_OVF_CLR = 4;
  localparam int CB_RAS_LO  = 5;
  localparam int CB_PRE_LO  = 8;

  typedef enum logic [1:0] {
    PM_NORMAL  = 2'b00,
    PM_SLEEP   = 2'b01,
    PM_STANDBY = 2'b10,
    PM_MANRST  = 2'b11
  } pwr_mode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CBR_CAS,
    ST_CBR_RAS,
    ST_CBR_REL,
    ST_PRE,
    ST_SR_CAS,
    ST_SR_HOLD,
    ST_SR_EXIT
  } seq_state_t;

  typedef struct packed {
    logic             ref_en;
    logic             sr_en;
    logic             irq_en;
    logic             keep_drive;
    logic [LEN_W-1:0] ras_len;
    logic [LEN_W-1:0] pre_len;
  } ctrl_t;
endpackage

// File: rtl/drc_regs.sv
module drc_regs
  import drc_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int TMR_W        = 16,
  parameter int CNT_W        = 10,
  parameter int DEF_INTERVAL = 780,
  parameter int DEF_RAS_LEN  = 3,
  parameter int DEF_PRE_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [TMR_W-1:0]  interval,
  output logic [CNT_W-1:0]  limit,
  output ctrl_t             ctrl,
  output logic              cnt_clr,
  output logic              ovf_clr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      interval        <= TMR_W'(DEF_INTERVAL);
      limit           <= '1;
      ctrl.ref_en     <= 1'b0;
      ctrl.sr_en      <= 1'b0;
      ctrl.irq_en     <= 1'b0;
      ctrl.keep_drive <= 1'b0;
      ctrl.ras_len    <= LEN_W'(DEF_RAS_LEN);
      ctrl.pre_len    <= LEN_W'(DEF_PRE_LEN);
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_INTERVAL: interval <= wr_data[TMR_W-1:0];
        ADDR_LIMIT:    limit    <= wr_data[CNT_W-1:0];
        ADDR_CTRL: begin
          ctrl.ref_en     <= wr_data[CB_REF_EN];
          ctrl.sr_en      <= wr_data[CB_SR_EN];
          ctrl.irq_en     <= wr_data[CB_IRQ_EN];
          ctrl.keep_drive <= wr_data[CB_KEEP];
          ctrl.ras_len    <= wr_data[CB_RAS_LO +: LEN_W];
          ctrl.pre_len    <= wr_data[CB_PRE_LO +: LEN_W];
        end
        default: ;
      endcase
    end
  end

  assign cnt_clr = wr_en && (wr_addr == ADDR_CLEAR);
  assign ovf_clr = wr_en && (wr_addr == ADDR_CTRL) && wr_data[CB_OVF_CLR];
endmodule

// File: rtl/drc_interval_timer.sv
module drc_interval_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMR_W-1:0] interval,
  output logic             tick
);
  logic [TMR_W-1:0] cnt_q;

  assign tick = run && (cnt_q >= interval);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/drc_event_counter.sv
module drc_event_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             cnt_clr,
  input  logic             ovf_clr,
  input  logic [CNT_W-1:0] limit,
  output logic             ovf_flag
);
  logic [CNT_W-1:0] count_q;
  logic             at_limit;

  assign at_limit = (count_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (cnt_clr)  count_q <= '0;
    else if (done)     count_q <= at_limit ? '0 : count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ovf_flag <= 1'b0;
    else if (done && !cnt_clr && at_limit) ovf_flag <= 1'b1;
    else if (ovf_clr)                    ovf_flag <= 1'b0;
  end
endmodule

// File: rtl/drc_cbr_seq.sv
module drc_cbr_seq
  import drc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ack,
  input  logic             standby,
  input  logic             sr_en,
  input  logic [LEN_W-1:0] ras_len,
  input  logic [LEN_W-1:0] pre_len,
  output logic             ras_n,
  output logic             cas_n,
  output logic             ref_req,
  output logic             done
);
  seq_state_t       state_q;
  logic [LEN_W-1:0] len_q;
  logic             pend_q;
  logic             start_cbr, start_sr, ras_last, pre_last;

  assign start_sr  = (state_q == ST_IDLE) && sr_en && ack;
  assign start_cbr = (state_q == ST_IDLE) && pend_q && ack && !standby && !sr_en;
  assign ras_last  = ({1'b0, len_q} + 1'b1) >= {1'b0, ras_len};
  assign pre_last  = ({1'b0, len_q} + 1'b1) >= {1'b0, pre_len};
  assign done      = (state_q == ST_CBR_REL);

  // One pending request at most; an expiry during a start re-arms it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (start_cbr) pend_q <= tick;
    else if (tick)      pend_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          len_q <= '0;
          if (start_sr)       state_q <= ST_SR_CAS;
          else if (start_cbr) state_q <= ST_CBR_CAS;
        end
        ST_CBR_CAS: state_q <= ST_CBR_RAS;
        ST_CBR_RAS: begin
          if (ras_last) begin
            state_q <= ST_CBR_REL;
            len_q   <= '0;
          end else begin
            len_q <= len_q + 1'b1;
          end
        end
        ST_CBR_REL, ST_SR_EXIT: begin
          len_q   <= '0;
          state_q <= (pre_len == '0) ? ST_IDLE : ST_PRE;
        end
        ST_PRE: begin
          if (pre_last) begin
            state_q <= ST_IDLE;
            len_q   <= '0;
          end else begin
            len_q <= len_q + 1'b1;
          end
        end
        ST_SR_CAS:  state_q <= ST_SR_HOLD;
        ST_SR_HOLD: if (!sr_en) state_q <= ST_SR_EXIT;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cas_n = 1'b1;
    ras_n = 1'b1;
    case (state_q)
      ST_CBR_CAS, ST_SR_CAS, ST_SR_EXIT: cas_n = 1'b0;
      ST_CBR_RAS, ST_SR_HOLD: begin
        cas_n = 1'b0;
        ras_n = 1'b0;
      end
      ST_CBR_REL: ras_n = 1'b0;
      default: ;
    endcase
  end

  assign ref_req = (state_q != ST_IDLE) || (pend_q && !standby) || sr_en;
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import drc_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int TMR_W        = 16,
  parameter int CNT_W        = 10,
  parameter int DEF_INTERVAL = 780
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        pwr_mode,
  input  logic              bus_released,
  input  logic              ref_ack,
  output logic              ref_req,
  output logic              ras_n,
  output logic              cas_n,
  output logic              ras_oe,
  output logic              cas_oe,
  output logic              irq
);
  logic [TMR_W-1:0] interval;
  logic [CNT_W-1:0] limit;
  ctrl_t            ctrl;
  logic             cnt_clr, ovf_clr, tick, done, ovf_flag;
  logic             standby, floating;
  logic             sr_en_w, irq_en_w, keep_w;

  assign standby  = (pwr_mode == PM_STANDBY);
  assign floating = bus_released || standby;
  assign sr_en_w  = ctrl.sr_en;
  assign irq_en_w = ctrl.irq_en;
  assign keep_w   = ctrl.keep_drive;

  drc_regs #(
    .DATA_W(DATA_W), .TMR_W(TMR_W), .CNT_W(CNT_W), .DEF_INTERVAL(DEF_INTERVAL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .interval(interval), .limit(limit), .ctrl(ctrl), .cnt_clr(cnt_clr), .ovf_clr(ovf_clr)
  );

  drc_interval_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(ctrl.ref_en && !standby),
    .interval(interval), .tick(tick)
  );

  drc_cbr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ack(ref_ack), .standby(standby),
    .sr_en(ctrl.sr_en), .ras_len(ctrl.ras_len), .pre_len(ctrl.pre_len),
    .ras_n(ras_n), .cas_n(cas_n), .ref_req(ref_req), .done(done)
  );

  drc_event_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .done(done), .cnt_clr(cnt_clr), .ovf_clr(ovf_clr),
    .limit(limit), .ovf_flag(ovf_flag)
  );

  assign irq    = ovf_flag && ctrl.irq_en;
  assign ras_oe = !floating || ctrl.keep_drive;
  assign cas_oe = !floating || ctrl.keep_drive;
endmodule

// File: rtl/drc_checker.sv
module drc_checker
  import drc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pwr_mode,
  input logic       bus_released,
  input logic       ref_ack,
  input logic       ref_req,
  input logic       ras_n,
  input logic       cas_n,
  input logic       ras_oe,
  input logic       cas_oe,
  input logic       irq,
  input logic       irq_en,
  input logic       sr_en,
  input logic       keep
);
  // R2
  cas_before_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  // R7
  start_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $past(ref_ack));

  // R7
  req_covers_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> ref_req);

  // R6
  no_cbr_in_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && ($past(pwr_mode) == PM_STANDBY)) |-> $past(sr_en));

  // R4
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);

  // R10
  pins_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_released && (pwr_mode != PM_STANDBY)) |-> (ras_oe && cas_oe));

  // R10
  pins_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_released || (pwr_mode == PM_STANDBY)) && !keep) |-> (!ras_oe && !cas_oe));

  // R8
  sr_exit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && !cas_n) |-> $past(!sr_en));
endmodule

bind dram_refresh_ctrl drc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode), .bus_released(bus_released),
  .ref_ack(ref_ack), .ref_req(ref_req), .ras_n(ras_n), .cas_n(cas_n),
  .ras_oe(ras_oe), .cas_oe(cas_oe), .irq(irq), .irq_en(irq_en_w),
  .sr_en(sr_en_w), .keep(keep_w)
);

// File: tb/sim_dram_refresh_ctrl.sv
`timescale 1ns/1ps
module sim_dram_refresh_ctrl;
  typedef struct packed {
    logic [15:0] interval;
    logic [2:0]  ras_len;
    logic [2:0]  pre_len;
    logic [1:0]  mode;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{16'd20, 3'd3, 3'd2, 2'b00},
    '{16'd9,  3'd1, 3'd0, 2'b01},
    '{16'd40, 3'd5, 3'd3, 2'b11},
    '{16'd15, 3'd7, 3'd1, 2'b00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  pwr_mode = 2'b00;
  logic        bus_released = 1'b0;
  logic        ref_ack = 1'b1;
  logic        ref_req, ras_n, cas_n, ras_oe, cas_oe, irq;

  always #2.5 clk = ~clk;

  dram_refresh_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwr_mode(pwr_mode), .bus_released(bus_released), .ref_ack(ref_ack),
    .ref_req(ref_req), .ras_n(ras_n), .cas_n(cas_n), .ras_oe(ras_oe),
    .cas_oe(cas_oe), .irq(irq)
  );

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Pin monitor, sampled away from the active edge
  int cas_falls = 0, ras_rises = 0;
  int cas_fall_at = 0, ras_fall_at = 0, cas_rise_at = 0, ras_rise_at = 0;
  int cas_gap = 0, cas_run = 0, ras_run = 0, cas_run_last = 0, ras_run_last = 0;
  logic pc = 1'b1, pr = 1'b1;
  always @(negedge clk) begin
    if (pc && !cas_n) begin
      cas_falls++;
      cas_gap = cyc - cas_fall_at;
      cas_fall_at = cyc;
    end
    if (!pc && cas_n) begin
      cas_rise_at = cyc;
      cas_run_last = cas_run;
    end
    if (pr && !ras_n) ras_fall_at = cyc;
    if (!pr && ras_n) begin
      ras_rises++;
      ras_rise_at = cyc;
      ras_run_last = ras_run;
    end
    cas_run = cas_n ? 0 : cas_run + 1;
    ras_run = ras_n ? 0 : ras_run + 1;
    pc = cas_n;
    pr = ras_n;
  end

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] mk_ctrl(input bit ren, input bit sr, input bit ie,
                                          input bit keep, input bit clr,
                                          input logic [2:0] rl, input logic [2:0] pl);
    return {5'b0, pl, rl, clr, keep, ie, sr, ren};
  endfunction

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rises(input int target);
    while (ras_rises < target) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiesce();
    wr(2'd3, mk_ctrl(0, 0, 0, 0, 1, 3'd3, 3'd2));
    idle_cycles(25);
  endtask

  initial begin
    int base;
    idle_cycles(3);
    // Reset state
    check("R1 reset ras_n", ras_n, 1);
    check("R2 reset cas_n", cas_n, 1);
    check("R4 reset irq", irq, 0);
    check("R7 reset ref_req", ref_req, 0);
    check("R10 reset ras_oe", ras_oe, 1);
    rst_n = 1'b1;
    idle_cycles(30);
    check("R1 no refresh while disabled", cas_falls, 0);

    // Vector table: period, strobe widths and order per mode
    for (int i = 0; i < NV; i++) begin
      quiesce();
      pwr_mode = VECS[i].mode;
      wr(2'd0, VECS[i].interval);
      wr(2'd3, mk_ctrl(1, 0, 0, 0, 0, VECS[i].ras_len, VECS[i].pre_len));
      base = ras_rises;
      wait_rises(base + 3);
      check($sformatf("R1 period vec%0d", i), cas_gap, int'(VECS[i].interval) + 1);
      check($sformatf("R2 cas width vec%0d", i), cas_run_last, int'(VECS[i].ras_len) + 1);
      check($sformatf("R2 ras width vec%0d", i), ras_run_last, int'(VECS[i].ras_len) + 1);
      check($sformatf("R2 cas leads ras vec%0d", i), ras_fall_at - cas_fall_at, 1);
      check($sformatf("R2 cas released first vec%0d", i), ras_rise_at - cas_rise_at, 1);
    end
    pwr_mode = 2'b00;

    // R3/R4: overflow after limit+1 refreshes
    quiesce();
    wr(2'd0, 16'd9);
    wr(2'd1, 16'd3);
    wr(2'd2, 16'd0);
    wr(2'd3, mk_ctrl(1, 0, 1, 0, 1, 3'd3, 3'd2));
    base = ras_rises;
    wait_rises(base + 3);
    check("R3 no overflow after limit refreshes", irq, 0);
    wait_rises(base + 4);
    check("R3 overflow on limit+1 refresh", irq, 1);
    wr(2'd3, mk_ctrl(0, 0, 0, 0, 0, 3'd3, 3'd2));
    idle_cycles(2);
    check("R4 irq masked by enable", irq, 0);
    wr(2'd3, mk_ctrl(0, 0, 1, 0, 0, 3'd3, 3'd2));
    idle_cycles(2);
    check("R4 flag kept while masked", irq, 1);
    wr(2'd3, mk_ctrl(0, 0, 1, 0, 1, 3'd3, 3'd2));
    idle_cycles(2);
    check("R4 flag cleared by write", irq, 0);

    // R5: count clear restarts the run towards overflow
    idle_cycles(25);
    wr(2'd2, 16'd0);
    wr(2'd3, mk_ctrl(1, 0, 1, 0, 0, 3'd3, 3'd2));
    base = ras_rises;
    wait_rises(base + 2);
    wr(2'd2, 16'd0);
    base = ras_rises;
    wait_rises(base + 3);
    check("R5 no overflow after clear", irq, 0);
    wait_rises(base + 4);
    check("R5 overflow counted from clear", irq, 1);

    // R7: wait for acknowledge, single pending request
    quiesce();
    ref_ack = 1'b0;
    base = cas_falls;
    wr(2'd3, mk_ctrl(1, 0, 0, 0, 0, 3'd3, 3'd2));
    idle_cycles(50);
    check("R7 no start without ack", cas_falls - base, 0);
    check("R7 cas idle while waiting", cas_n, 1);
    check("R7 ref_req while waiting", ref_req, 1);
    wr(2'd3, mk_ctrl(0, 0, 0, 0, 0, 3'd3, 3'd2));
    base = cas_falls;
    ref_ack = 1'b1;
    idle_cycles(40);
    check("R7 single queued refresh", cas_falls - base, 1);
    check("R7 ref_req drops after service", ref_req, 0);

    // R6/R10: standby
    quiesce();
    pwr_mode = 2'b10;
    base = cas_falls;
    wr(2'd3, mk_ctrl(1, 0, 0, 0, 0, 3'd3, 3'd2));
    idle_cycles(60);
    check("R6 no refresh in standby", cas_falls - base, 0);
    check("R10 ras floats in standby", ras_oe, 0);
    check("R10 cas floats in standby", cas_oe, 0);
    wr(2'd3, mk_ctrl(1, 0, 0, 1, 0, 3'd3, 3'd2));
    idle_cycles(1);
    check("R10 keep bit drives ras", ras_oe, 1);
    check("R10 keep bit drives cas", cas_oe, 1);
    pwr_mode = 2'b00;
    base = cas_falls;
    idle_cycles(25);
    check("R6 refresh resumes after standby", (cas_falls - base) >= 1, 1);
    wr(2'd3, mk_ctrl(1, 0, 0, 0, 0, 3'd3, 3'd2));
    bus_released = 1'b1;
    idle_cycles(1);
    check("R10 ras floats on bus release", ras_oe, 0);
    bus_released = 1'b0;
    idle_cycles(1);
    check("R10 ras driven after bus return", ras_oe, 1);

    // R8/R9: self-refresh entry, standby hold, exit and precharge
    quiesce();
    wr(2'd0, 16'd5);
    wr(2'd3, mk_ctrl(0, 1, 0, 1, 0, 3'd3, 3'd2));
    idle_cycles(10);
    check("R8 ras held low", ras_n, 0);
    check("R8 cas held low", cas_n, 0);
    check("R8 entry cas leads ras", ras_fall_at - cas_fall_at, 1);
    pwr_mode = 2'b10;
    idle_cycles(5);
    check("R8 ras held in standby", ras_n, 0);
    check("R8 ras driven in standby", ras_oe, 1);
    pwr_mode = 2'b00;
    wr(2'd3, mk_ctrl(1, 1, 0, 1, 0, 3'd3, 3'd2));
    idle_cycles(20);
    check("R8 no CBR during self-refresh", cas_n, 0);
    base = cas_falls;
    wr(2'd3, mk_ctrl(1, 0, 0, 1, 0, 3'd3, 3'd2));
    while (cas_falls <= base) @(posedge clk);
    @(negedge clk);
    check("R8 exit raises ras before cas", cas_rise_at - ras_rise_at, 1);
    check("R9 precharge gap before next refresh", cas_fall_at - cas_rise_at, 3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule